// File: doc/BRIEF.md
# Comparator Output Conditioner

This block cleans up the single-bit output of an analog comparator before the rest of the chip acts on it. It runs on the bus clock. Every path through it first registers the raw bit into that domain. It can then forward the bit directly, hold it outside a window, resample it at a fixed rate, or filter it. Filtering means a new level is taken only after it has been seen on a programmed number of samples in a row.

Samples are timed either by an internal prescaler that counts bus clocks or by the rising edges of an external sample clock. The external clock first passes through a two-flop synchronizer. A window input can gate the output, so that the comparator is only listened to while the window input is high. Setting the window enable always selects the prescaler as the sample source, whatever the sample enable says.

Mode selection from the configuration inputs, with the enable high: window off and sample enable high with a nonzero filter count gives external sampling. Window off otherwise gives pass-through when the filter count or the prescaler is zero, resampling when the filter count is one, and filtering when it is larger. Window on gives window-only when the filter count or the prescaler is zero, windowed resampling when the filter count is one, and windowed filtering when it is larger.

Top module: `cmp_cond`

## Requirements
- R1: While `en` is 0, `cout` is 0 one clock later, and all filter state is cleared. After a re-enable in a filter mode, the output therefore starts from 0 and is not a level that was seen before the disable.
- R2: In pass-through mode (`win_en`=0, and either `filt_cnt`=0, or `samp_en`=0 with `prescale`=0), `cout` equals `raw_in` delayed by exactly two clocks.
- R3: In resample mode (`win_en`=0, `samp_en`=0, `filt_cnt`=1, `prescale`=p>0), the registered input is sampled once every p clocks. A new level reaches `cout` no earlier than 2 clocks and no later than p+2 clocks after it appears on `raw_in`.
- R4: In filter mode (`win_en`=0, `samp_en`=0, `filt_cnt`=n>1, `prescale`=p>0), a new level is accepted only after n consecutive samples show it. It reaches `cout` after more than (n-1)·p+1 clocks and within n·p+2 clocks.
- R5: A sample that matches the current output before n differing samples have been counted restarts the count and leaves `cout` unchanged. For example, the pattern 1,1,0,1,1 with n=3 and p=1 is never accepted, and a one-clock pulse with p=4 and n=2 is never accepted.
- R6: In external-sample mode (`win_en`=0, `samp_en`=1, `filt_cnt`=n≥1), samples are taken only on synchronized rising edges of `samp_clk`. With no edge, `cout` never changes. A new level is accepted on the n-th consecutive edge that shows it.
- R7: With `win_en`=1 and `win_in`=0, `cout` holds its value whatever `raw_in` does.
- R8: With `win_en`=1, `win_in`=1 and `filt_cnt`=0 or `prescale`=0, `cout` equals `raw_in` delayed by two clocks.
- R9: With `win_en`=1, `samp_en` has no effect and samples come from the prescaler. With `filt_cnt`=1, a new level appears within p+2 clocks. With `filt_cnt`=n>1, it appears within n·p+2 clocks and not within 2 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable; 0 forces the output low |
| win_en | input | 1 | Window mode enable |
| samp_en | input | 1 | Select the external sample clock (ignored when win_en=1) |
| filt_cnt | input | FCNT_W | Consecutive samples needed to accept a level |
| prescale | input | PRE_W | Sample period in bus clocks |
| raw_in | input | 1 | Raw comparator bit |
| win_in | input | 1 | Window gate, high = listen |
| samp_clk | input | 1 | External sample clock, asynchronous |
| cout | output | 1 | Conditioned comparator bit |

## Verification
The direct path is driven with single-clock level changes so that an exact two-clock delay can be told apart from any other delay. The prescaled paths are driven with held steps and checked at both ends of the latency window, which exposes a wrong sample period or a wrong count. Short pulses and broken runs such as 1,1,0,1,1 separate a filter that restarts on a mismatch from one that only accumulates. Runs with no external edges show whether the sample source is really the external clock or, in window modes, really the prescaler. A disable with a high input, followed by a re-enable into a slow filter, shows whether stale filter state survives.

// File: rtl/cmp_cond_pkg.sv
package cmp_cond_pkg;

  typedef enum logic [2:0] {
    MD_OFF    = 3'd0,
    MD_PASS   = 3'd1,
    MD_RESAMP = 3'd2,
    MD_FILT   = 3'd3,
    MD_EXT    = 3'd4,
    MD_WIN    = 3'd5,
    MD_WRES   = 3'd6,
    MD_WFILT  = 3'd7
  } cc_mode_e;

  // Pick the operating mode from the configuration inputs.
  function automatic cc_mode_e decode_mode(logic en, logic win, logic samp,
                                           logic [31:0] fcnt, logic [31:0] pre);
    cc_mode_e m;
    if (!en)                            m = MD_OFF;
    else if (win) begin
      if (fcnt == 0 || pre == 0)        m = MD_WIN;
      else if (fcnt == 1)               m = MD_WRES;
      else                              m = MD_WFILT;
    end
    else if (samp && fcnt != 0)         m = MD_EXT;
    else if (fcnt == 0 || pre == 0)     m = MD_PASS;
    else if (fcnt == 1)                 m = MD_RESAMP;
    else                                m = MD_FILT;
    return m;
  endfunction

  // Modes in which the sample/filter stage drives the output.
  function automatic logic uses_filter(cc_mode_e m);
    return (m == MD_RESAMP) || (m == MD_FILT) || (m == MD_EXT) ||
           (m == MD_WRES)   || (m == MD_WFILT);
  endfunction

  // Modes in which the prescaler supplies the sample ticks.
  function automatic logic uses_prescaler(cc_mode_e m);
    return (m == MD_RESAMP) || (m == MD_FILT) ||
           (m == MD_WRES)   || (m == MD_WFILT);
  endfunction

endpackage

// File: rtl/cmp_cond_ticker.sv
module cmp_cond_ticker #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] prescale,
  output logic             tick
);

  logic [PRE_W-1:0] cnt_q;
  logic             last;

  assign last = (cnt_q == prescale - PRE_W'(1));
  assign tick = run && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (last)     cnt_q <= '0;
    else               cnt_q <= cnt_q + PRE_W'(1);
  end

endmodule

// File: rtl/cmp_cond_edge.sv
module cmp_cond_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);

  localparam int TAPS = SYNC_STAGES + 1;

  logic [TAPS-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[TAPS-2:0], async_in};
  end

  assign rise = sh_q[TAPS-2] && !sh_q[TAPS-1];

endmodule

// File: rtl/cmp_cond_filter.sv
module cmp_cond_filter #(
  parameter int FCNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              active,
  input  logic              tick,
  input  logic              din,
  input  logic [FCNT_W-1:0] thresh,
  output logic              dout,
  output logic              accept
);

  logic [FCNT_W-1:0] run_q;
  logic [FCNT_W:0]   run_nxt;
  logic              differs;

  assign differs = (din != dout);
  assign run_nxt = {1'b0, run_q} + 1'b1;
  assign accept  = active && tick && differs && (run_nxt >= {1'b0, thresh});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout  <= 1'b0;
      run_q <= '0;
    end else if (clr) begin
      dout  <= 1'b0;
      run_q <= '0;
    end else if (!active) begin
      dout  <= din;
      run_q <= '0;
    end else if (tick) begin
      if (!differs)    run_q <= '0;
      else if (accept) begin
        dout  <= din;
        run_q <= '0;
      end
      else             run_q <= run_nxt[FCNT_W-1:0];
    end
  end

endmodule

// File: rtl/cmp_cond.sv
module cmp_cond
  import cmp_cond_pkg::*;
#(
  parameter int FCNT_W      = 8,
  parameter int PRE_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              win_en,
  input  logic              samp_en,
  input  logic [FCNT_W-1:0] filt_cnt,
  input  logic [PRE_W-1:0]  prescale,
  input  logic              raw_in,
  input  logic              win_in,
  input  logic              samp_clk,
  output logic              cout
);

  cc_mode_e mode;
  logic     raw_q;
  logic     active;
  logic     pre_run;
  logic     pre_tick;
  logic     smp_edge;
  logic     filt_tick;
  logic     filt_q;
  logic     filt_acc;

  assign mode    = decode_mode(en, win_en, samp_en, 32'(filt_cnt), 32'(prescale));
  assign active  = uses_filter(mode);
  assign pre_run = uses_prescaler(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= 1'b0;
    else        raw_q <= raw_in;
  end

  cmp_cond_ticker #(.PRE_W(PRE_W)) u_ticker (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (pre_run),
    .prescale (prescale),
    .tick     (pre_tick)
  );

  cmp_cond_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (samp_clk),
    .rise     (smp_edge)
  );

  assign filt_tick = (mode == MD_EXT) ? smp_edge : pre_tick;

  cmp_cond_filter #(.FCNT_W(FCNT_W)) u_filter (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (mode == MD_OFF),
    .active (active),
    .tick   (filt_tick),
    .din    (raw_q),
    .thresh (filt_cnt),
    .dout   (filt_q),
    .accept (filt_acc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cout <= 1'b0;
    else if (mode == MD_OFF)    cout <= 1'b0;
    else if (win_en && !win_in) cout <= cout;
    else                        cout <= active ? filt_q : raw_q;
  end

endmodule

// File: rtl/cmp_cond_chk.sv
module cmp_cond_chk
  import cmp_cond_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             win_en,
  input logic             win_in,
  input logic             cout,
  input logic             raw_q,
  input cc_mode_e         mode,
  input logic             active,
  input logic             pre_tick,
  input logic             smp_edge,
  input logic             filt_tick,
  input logic             filt_q,
  input logic [PRE_W-1:0] prescale
);

  // R1
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !cout);

  // R2
  pass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_PASS) |=> (cout == $past(raw_q)));

  // R7
  win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && win_en && !win_in) |=> $stable(cout));

  // R4
  filt_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && $past(active) && (filt_q != $past(filt_q))) |-> $past(filt_tick));

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_tick && prescale > PRE_W'(1)) |=> (!pre_tick || prescale == PRE_W'(1)));

  // R6
  edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_edge |=> !smp_edge);

endmodule

bind cmp_cond cmp_cond_chk #(.PRE_W(PRE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .win_en    (win_en),
  .win_in    (win_in),
  .cout      (cout),
  .raw_q     (raw_q),
  .mode      (mode),
  .active    (active),
  .pre_tick  (pre_tick),
  .smp_edge  (smp_edge),
  .filt_tick (filt_tick),
  .filt_q    (filt_q),
  .prescale  (prescale)
);

// File: tb/cmp_cond_bench.sv
`timescale 1ns/1ps
module cmp_cond_bench;

  localparam int FW = 8;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic          win_en = 1'b0;
  logic          samp_en = 1'b0;
  logic [FW-1:0] filt_cnt = '0;
  logic [PW-1:0] prescale = '0;
  logic          raw_in = 1'b0;
  logic          win_in = 1'b0;
  logic          samp_clk = 1'b0;
  logic          cout;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  cmp_cond #(.FCNT_W(FW), .PRE_W(PW)) u_cmp_cond (
    .clk(clk), .rst_n(rst_n), .en(en), .win_en(win_en), .samp_en(samp_en),
    .filt_cnt(filt_cnt), .prescale(prescale), .raw_in(raw_in),
    .win_in(win_in), .samp_clk(samp_clk), .cout(cout)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: cout=%0b expected %0b", tag, act, exp);
    end
  endtask

  // Disable, clear the input, then apply a configuration and let it settle.
  task automatic setup(input logic w, input logic s, input int f, input int p);
    en = 1'b0; raw_in = 1'b0; win_in = 1'b0;
    cyc(2);
    win_en = w; samp_en = s; filt_cnt = FW'(f); prescale = PW'(p);
    en = 1'b1;
    cyc(4);
  endtask

  task automatic t_reset();
    chk("R1 reset value", cout, 1'b0);
  endtask

  task automatic t_pass();
    setup(1'b0, 1'b0, 0, 0);
    raw_in = 1'b1; cyc(1); chk("R2 pass one clock", cout, 1'b0);
    raw_in = 1'b0; cyc(1); chk("R2 pass two clocks", cout, 1'b1);
    cyc(1);        chk("R2 pass falls", cout, 1'b0);
    setup(1'b0, 1'b0, 3, 0);
    raw_in = 1'b1; cyc(2); chk("R2 pass zero prescale", cout, 1'b1);
  endtask

  task automatic t_resample();
    setup(1'b0, 1'b0, 1, 4);
    raw_in = 1'b1; cyc(1); chk("R3 not before 2", cout, 1'b0);
    cyc(5);        chk("R3 within p+2", cout, 1'b1);
  endtask

  task automatic t_filter();
    setup(1'b0, 1'b0, 3, 2);
    raw_in = 1'b1; cyc(4); chk("R4 early", cout, 1'b0);
    cyc(5);        chk("R4 within n*p+2", cout, 1'b1);
  endtask

  task automatic t_restart();
    setup(1'b0, 1'b0, 3, 1);
    raw_in = 1'b1; cyc(1); raw_in = 1'b1; cyc(1); raw_in = 1'b0; cyc(1);
    raw_in = 1'b1; cyc(1); raw_in = 1'b1; cyc(1); raw_in = 1'b0; cyc(4);
    chk("R5 broken run rejected", cout, 1'b0);
    raw_in = 1'b1; cyc(6);
    chk("R5 full run accepted", cout, 1'b1);
    setup(1'b0, 1'b0, 2, 4);
    raw_in = 1'b1; cyc(1); raw_in = 1'b0; cyc(12);
    chk("R5 short pulse rejected", cout, 1'b0);
  endtask

  task automatic pulse_samp();
    samp_clk = 1'b1; cyc(4); samp_clk = 1'b0; cyc(4);
  endtask

  task automatic t_ext();
    setup(1'b0, 1'b1, 2, 3);
    raw_in = 1'b1; cyc(20);
    chk("R6 no edge no change", cout, 1'b0);
    pulse_samp(); cyc(4);
    chk("R6 one edge of two", cout, 1'b0);
    pulse_samp(); cyc(4);
    chk("R6 accepted on second edge", cout, 1'b1);
  endtask

  task automatic t_window();
    setup(1'b1, 1'b0, 0, 0);
    raw_in = 1'b1; win_in = 1'b1; cyc(1);
    chk("R8 window one clock", cout, 1'b0);
    cyc(1); chk("R8 window two clocks", cout, 1'b1);
    win_in = 1'b0;
    for (int i = 0; i < 6; i++) begin
      raw_in = i[0]; cyc(1);
      chk("R7 hold while closed", cout, 1'b1);
    end
    raw_in = 1'b0; cyc(3);
    chk("R7 hold after closing", cout, 1'b1);
    win_in = 1'b1; cyc(2);
    chk("R8 follows when open", cout, 1'b0);
  endtask

  task automatic t_win_presc();
    setup(1'b1, 1'b1, 1, 3);
    win_in = 1'b1; raw_in = 1'b1; cyc(6);
    chk("R9 windowed resample ignores samp_en", cout, 1'b1);
    setup(1'b1, 1'b1, 2, 2);
    win_in = 1'b1; raw_in = 1'b1; cyc(2);
    chk("R9 windowed filter early", cout, 1'b0);
    cyc(5);
    chk("R9 windowed filter within n*p+2", cout, 1'b1);
  endtask

  task automatic t_disable();
    setup(1'b0, 1'b0, 0, 0);
    raw_in = 1'b1; cyc(3);
    chk("R1 pass high before disable", cout, 1'b1);
    en = 1'b0; cyc(1);
    chk("R1 low after disable", cout, 1'b0);
    cyc(2);
    filt_cnt = FW'(4); prescale = PW'(4); en = 1'b1; cyc(2);
    chk("R1 filter state cleared", cout, 1'b0);
    cyc(17);
    chk("R1 filter accepts after re-enable", cout, 1'b1);
  endtask

  initial begin
    #(4 * 100000);
    bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_pass();
    t_resample();
    t_filter();
    t_restart();
    t_ext();
    t_window();
    t_win_presc();
    t_disable();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule